// File: doc/BRIEF.md
# Serial Gain Register Port

This block is the control-side register port of a two-channel gain controller. An external host reaches it over a four-wire synchronous serial link made of an active-low chip select, a serial clock, a data input and a data output. The port holds a 6-bit gain code and a serial enable bit for each of the two channels, and it drives them to the gain stages as plain parallel outputs.

The serial pins are brought into the system clock domain through synchronisers, and their edges are detected there. Each time chip select goes low, a new access begins. An access is a fixed 16-bit word, sent most significant bit first. A write is applied at the moment chip select is released, and only if exactly sixteen serial clock rising edges were seen. A frame with fewer or more clocks is dropped without any effect. On a read, the addressed register is returned on the data output during the last eight clocks of the frame.

Top module: `spi_gain_port`

## Requirements
- R1: After reset, both gain outputs are 0, both enable outputs are 1, and `spi_miso` and `spi_miso_oe` are 0.
- R2: The host sends each frame MSB first, and the port samples each bit on a rising edge of `spi_sclk`. In the frame, bit 15 is the access kind (0 = write, 1 = read), bits 14:8 are the address and bits 7:0 are the data.
- R3: A write is applied when `spi_cs_n` rises after exactly 16 rising edges. Address 0 sets channel A and address 1 sets channel B. The data bits 5:0 become the gain and data bit 7 becomes the enable. The outputs keep their old values while chip select is still low.
- R4: If `spi_cs_n` rises after fewer than 16 rising edges, no register changes.
- R5: If `spi_cs_n` rises after more than 16 rising edges, no register changes. The edge counter saturates and does not wrap.
- R6: A complete write to any address from 2 to 127 changes no output.
- R7: On a read, the register byte {enable, 0, gain[5:0]} is shifted out on `spi_miso`, MSB first, during clocks 9 to 16. Each bit is launched on a falling edge of `spi_sclk` and is valid at the next rising edge. Unmapped addresses read as 0x00. A read changes no register.
- R8: `spi_miso_oe` is 1 only while chip select is low. `spi_miso` is 0 whenever no read data bit is being driven.
- R9: Every fall of chip select starts a new frame. Bits from an earlier aborted frame do not carry into the next frame.
- R10: Write data bit 6 is not stored, and it always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, may idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data to the host |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (high-impedance when 0) |
| gain_a | output | 6 | Channel A gain code |
| en_a | output | 1 | Channel A serial enable |
| gain_b | output | 6 | Channel B gain code |
| en_b | output | 1 | Channel B serial enable |

## Verification
Each serial pin passes through two synchroniser stages and one edge-detect stage, so the port reacts to a pin change three system clocks later. Results therefore appear as follows:
- A read bit launched on a falling serial clock edge appears on `spi_miso` about four system clocks after that edge.
- A committed write reaches the gain outputs about four system clocks after chip select rises.

The bench holds each serial clock phase for eight system clocks and samples `spi_miso` at the end of the low phase, just before it raises the clock. It checks the register outputs and the output enable twelve system clocks after each release, when every path has settled.

// File: rtl/spi_gain_pkg.sv
package spi_gain_pkg;

    localparam int FRAME_BITS = 16;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int GAIN_W     = 6;
    localparam int NUM_CH     = 2;

    // bit of a register byte that carries the channel enable
    localparam int EN_BIT = DATA_W - 1;

    // stored bits of a register byte: enable and gain, bit 6 dropped
    localparam logic [DATA_W-1:0] REG_MASK =
        DATA_W'((1 << EN_BIT) | ((1 << GAIN_W) - 1));

    // register byte after reset: enabled, gain zero
    localparam logic [DATA_W-1:0] REG_RESET = DATA_W'(1 << EN_BIT);

    typedef enum logic {
        ACC_WRITE = 1'b0,
        ACC_READ  = 1'b1
    } acc_e;

    typedef struct packed {
        acc_e              kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic logic [DATA_W-1:0] reg_clean(input logic [DATA_W-1:0] raw);
        return raw & REG_MASK;
    endfunction

    function automatic logic [GAIN_W-1:0] reg_gain(input logic [DATA_W-1:0] r);
        return r[GAIN_W-1:0];
    endfunction

    function automatic logic reg_en(input logic [DATA_W-1:0] r);
        return r[EN_BIT];
    endfunction

endpackage

// File: rtl/spi_gain_sync.sv
module spi_gain_sync #(
    parameter int                 WIDTH   = 3,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= chain[STAGES-1];
    end

    assign lvl_o  = chain[STAGES-1];
    assign rise_o = chain[STAGES-1] & ~prev;
    assign fall_o = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/spi_gain_shifter.sv
module spi_gain_shifter
    import spi_gain_pkg::*;
#(
    parameter int NBITS = FRAME_BITS,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_low,
    input  logic          cs_fall,
    input  logic          cs_rise,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          mosi,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          commit,
    output frame_t        frame,
    output logic          miso
);

    localparam int CNT_MAX = NBITS + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int HDR     = NBITS - DW;

    logic [NBITS-1:0] shreg;
    logic [CNT_W-1:0] cnt;
    logic [DW-1:0]    out_sr;
    logic             tx_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (cs_fall) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (cs_low && sclk_rise) begin
            shreg <= {shreg[NBITS-2:0], mosi};
            if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
        end
    end

    // after HDR rising edges the low bits hold {kind, addr}
    assign rd_addr = shreg[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst || cs_fall || !cs_low) begin
            tx_on  <= 1'b0;
            out_sr <= '0;
        end else if (sclk_fall) begin
            if (cnt == CNT_W'(HDR) && shreg[AW] == ACC_READ) begin
                tx_on  <= 1'b1;
                out_sr <= rd_data;
            end else if (cnt >= CNT_W'(NBITS)) begin
                tx_on  <= 1'b0;
                out_sr <= '0;
            end else if (tx_on) begin
                out_sr <= {out_sr[DW-2:0], 1'b0};
            end
        end
    end

    assign miso   = tx_on & cs_low & out_sr[DW-1];
    assign commit = cs_rise && (cnt == CNT_W'(NBITS));
    assign frame  = frame_t'(shreg);

    // R5: the edge counter saturates one past a full frame
    p_cnt_sat_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(CNT_MAX));

    // R8: no read data outside an asserted chip select
    p_miso_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !cs_low |-> !miso);

    // R9: a new frame always starts from an empty count
    p_fresh_r9: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> (cnt == '0));

endmodule

// File: rtl/spi_gain_regfile.sv
module spi_gain_regfile
    import spi_gain_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W,
    parameter int GW  = GAIN_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   commit,
    input  frame_t                 frame,
    input  logic [AW-1:0]          rd_addr,
    output logic [DW-1:0]          rd_data,
    output logic [NCH-1:0][GW-1:0] gain_o,
    output logic [NCH-1:0]         en_o
);

    logic [DW-1:0] regs [NCH];

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            always_ff @(posedge clk) begin
                if (rst)
                    regs[c] <= REG_RESET;
                else if (commit && frame.kind == ACC_WRITE && frame.addr == AW'(c))
                    regs[c] <= reg_clean(frame.data);
            end
            assign gain_o[c] = reg_gain(regs[c]);
            assign en_o[c]   = reg_en(regs[c]);
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NCH; c++) begin
            if (rd_addr == AW'(c)) rd_data = regs[c];
        end
    end

    // R10: the unused bit position never holds a one
    p_bit6_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~REG_MASK) == '0);

endmodule

// File: rtl/spi_gain_port.sv
module spi_gain_port
    import spi_gain_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [GAIN_W-1:0] gain_a,
    output logic              en_a,
    output logic [GAIN_W-1:0] gain_b,
    output logic              en_b
);

    localparam int PIN_CS   = 2;
    localparam int PIN_SCLK = 1;
    localparam int PIN_MOSI = 0;

    logic [2:0] lvl, rise, fall;
    logic       cs_low;
    logic       commit;
    frame_t     frame;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [NUM_CH-1:0][GAIN_W-1:0] gains;
    logic [NUM_CH-1:0]             ens;

    spi_gain_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) sync_i (
        .clk   (clk),
        .rst   (rst),
        .pin_i ({spi_cs_n, spi_sclk, spi_mosi}),
        .lvl_o (lvl),
        .rise_o(rise),
        .fall_o(fall)
    );

    assign cs_low = ~lvl[PIN_CS];

    spi_gain_shifter shift_i (
        .clk      (clk),
        .rst      (rst),
        .cs_low   (cs_low),
        .cs_fall  (fall[PIN_CS]),
        .cs_rise  (rise[PIN_CS]),
        .sclk_rise(rise[PIN_SCLK]),
        .sclk_fall(fall[PIN_SCLK]),
        .mosi     (lvl[PIN_MOSI]),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .commit   (commit),
        .frame    (frame),
        .miso     (spi_miso)
    );

    spi_gain_regfile regs_i (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .frame  (frame),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .gain_o (gains),
        .en_o   (ens)
    );

    assign spi_miso_oe = cs_low;
    assign gain_a = gains[0];
    assign en_a   = ens[0];
    assign gain_b = gains[1];
    assign en_b   = ens[1];

    // R4 R5: a release without a full frame leaves every register alone
    p_abort_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (rise[PIN_CS] && !commit) |=> ($stable(gains) && $stable(ens)));

    // R3: registers only move at a chip select release
    p_hold_low_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(commit) |-> ($stable(gains) && $stable(ens)));

    // R3: a committed write to address 0 lands on channel A
    p_write_a_r3: assert property (@(posedge clk) disable iff (rst)
        (commit && frame.kind == ACC_WRITE && frame.addr == '0)
            |=> (gain_a == $past(frame.data[GAIN_W-1:0]) && en_a == $past(frame.data[DATA_W-1])));

    // R7: a read frame leaves the registers unchanged
    p_read_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (commit && frame.kind == ACC_READ) |=> ($stable(gains) && $stable(ens)));

endmodule

// File: tb/spi_gain_port_tb.sv
module spi_gain_port_tb_top;

    localparam int HP = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic miso, miso_oe;
    logic [5:0] gain_a, gain_b;
    logic en_a, en_b;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_reg [2];
    logic [7:0] rd_got;
    logic       oe_seen;

    always #5 clk = ~clk;

    spi_gain_port dut_i (
        .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe),
        .gain_a(gain_a), .en_a(en_a), .gain_b(gain_b), .en_b(en_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [6:0] a);
        return (a < 7'd2) ? exp_reg[a[0]] : 8'h00;
    endfunction

    function automatic logic [15:0] mk(input logic rd, input logic [6:0] a, input logic [7:0] d);
        return {rd, a, d};
    endfunction

    task automatic frame(input logic [15:0] w, input int nclk);
        rd_got  = '0;
        oe_seen = 1'b0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            mosi = (i < 16) ? w[15-i] : 1'b0;
            repeat (HP) @(negedge clk);
            if (i >= 8 && i < 16) rd_got[15-i] = miso;
            if (miso_oe) oe_seen = 1'b1;
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic do_frame(input string req, input logic [15:0] w, input int nclk);
        logic [7:0] exp_rd;
        exp_rd = model_read(w[14:8]);
        frame(w, nclk);
        if (nclk == 16 && !w[15] && w[14:8] < 7'd2)
            exp_reg[w[8]] = w[7:0] & 8'hBF;
        if (nclk >= 16 && w[15]) chk({req, " R7 readback"}, rd_got, exp_rd);
        if (nclk > 0) chk({req, " R8 oe during frame"}, oe_seen, 1'b1);
        chk({req, " R8 oe idle"}, {miso_oe, miso}, 2'b00);
        chk({req, " regs"}, {en_a, gain_a, en_b, gain_b},
            {exp_reg[0][7], exp_reg[0][5:0], exp_reg[1][7], exp_reg[1][5:0]});
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED));
        exp_reg[0] = 8'h80;
        exp_reg[1] = 8'h80;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 reset", {en_a, gain_a, en_b, gain_b, miso, miso_oe}, {1'b1, 6'd0, 1'b1, 6'd0, 2'b00});

        // R2 R3: write channel A, then B, MSB-first frames
        do_frame("R2 R3 wr A", mk(1'b0, 7'd0, 8'h2A), 16);
        do_frame("R3 wr B", mk(1'b0, 7'd1, 8'h15), 16);
        // R3 outputs unchanged while chip select still low
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            mosi = mk(1'b0, 7'd0, 8'h3F)[15-i];
            repeat (HP) @(negedge clk);
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (3 * HP) @(negedge clk);
        chk("R3 no change before release", {en_a, gain_a}, {1'b0, 6'h2A});
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
        exp_reg[0] = 8'h3F;
        chk("R3 applied at release", {en_a, gain_a}, {1'b0, 6'h3F});

        // R7 readback of both channels, R10 bit 6 dropped
        do_frame("R10 wr bit6", mk(1'b0, 7'd1, 8'hC5), 16);
        do_frame("R7 R10 rd B", mk(1'b1, 7'd1, 8'hFF), 16);
        chk("R10 bit6 reads 0", rd_got, 8'h85);
        do_frame("R7 rd A", mk(1'b1, 7'd0, 8'h00), 16);
        do_frame("R7 rd unmapped", mk(1'b1, 7'd55, 8'h00), 16);
        chk("R7 unmapped is 0", rd_got, 8'h00);

        // R4 short frame, R5 long frame, R6 unmapped write
        do_frame("R4 short", mk(1'b0, 7'd0, 8'h81), 15);
        do_frame("R4 very short", mk(1'b0, 7'd1, 8'h00), 3);
        do_frame("R5 long", mk(1'b0, 7'd0, 8'h81), 17);
        do_frame("R5 very long", mk(1'b0, 7'd1, 8'h00), 24);
        do_frame("R6 wr addr 2", mk(1'b0, 7'd2, 8'h00), 16);
        do_frame("R6 wr addr 127", mk(1'b0, 7'd127, 8'h00), 16);

        // R9 aborted frame followed by a full frame
        do_frame("R9 abort", mk(1'b1, 7'd1, 8'hFF), 7);
        do_frame("R9 fresh", mk(1'b0, 7'd1, 8'h07), 16);
        chk("R9 fresh frame value", {en_b, gain_b}, {1'b0, 6'h07});

        // random mix
        for (int k = 0; k < 70; k++) begin
            logic [15:0] w;
            int n;
            int sel;
            w = 16'($urandom);
            sel = int'($urandom % 4);
            if (sel < 3) w[14:8] = 7'($urandom % 2);
            sel = int'($urandom % 6);
            n = (sel == 0) ? 15 : (sel == 1) ? 17 : (sel == 2) ? int'($urandom % 21) : 16;
            do_frame("R2 random", w, n);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule